// File: doc/BRIEF.md
# Addressed Serial Register Control Port

This block is the slave side of a three-wire control link. The wires are an active-low select, a serial clock, and a data line that works in both directions. A host sends frames of 16 bits. Each frame is an address byte followed by a data byte. The address byte carries a 4-bit register address and a direction flag. The port uses the frame to either load one of a few small control registers or return a register's contents on the same data line. It never drives the pad directly: it produces the outgoing bit and the enable for an external tri-state driver.

The register set has the following members:
- a gain code for the left channel;
- a gain code for the right channel;
- a reference code for the peak comparators;
- a two-bit overload flag register whose flags stay set until they are read;
- a test register, which can turn the mute pad into an output that shows one of eight internal signals.

One extra address is write-only and loads both gain codes from a single frame. Every gain load pulses an update strobe toward the gain-change logic. The serial inputs are asynchronous to the system clock. They are synchronised first, and edges are detected on the synchronised copies.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, both gain codes, the test register and the overload flags are 0, and the peak reference code is 255. `sdaOe` and `muteOe` are low.
- R2: While `selN` is low, a bit is taken on each rising `serClk` edge, MSB first. The address register is bits 6..3 of the first byte. Bit 2 of the first byte is the direction (1 = read, 0 = write). Bits 7, 1 and 0 of the first byte are ignored.
- R3: A complete write frame loads its second byte into the register at the decoded address. The addresses are 1101 = left gain, 1110 = right gain, 1100 = peak reference, 1111 = test. A left or right gain load raises that side's strobe for exactly one system clock.
- R4: A write to address 1001 loads the same byte into both gain codes, and both strobes pulse in the same cycle.
- R5: In a read frame, the falling `serClk` edges after the 8th rising edge drive the addressed register out on `sdaOut`, MSB first, with `sdaOe` high. Address 1011 returns {6'b0, left flag, right flag}. Address 1001 and unmapped addresses return 0. A read frame changes no register other than the overload flags.
- R6: `sdaOe` is low whenever `selN` is high, and it is low after the 16th falling `serClk` edge of a frame.
- R7: A one-cycle pulse on `peakHitLeft` sets overload bit 1, and a pulse on `peakHitRight` sets bit 0. A flag stays set until a complete read frame of address 1011 ends. That read clears only the flags it reported, so a pulse that arrives during the read survives.
- R8: If `selN` rises before the 16th rising edge, the frame is dropped: no register changes and no strobe pulses. The next frame decodes normally. A write to address 1011 has no effect.
- R9: While test bit 1 is set, `muteOe` is high and `muteOut` equals `tapSignals[test[4:2]]`. While test bit 1 is clear, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock from the host (asynchronous) |
| selN | input | 1 | Active-low frame select (asynchronous) |
| sdaIn | input | 1 | Serial data from the pad |
| sdaOut | output | 1 | Serial read data toward the pad |
| sdaOe | output | 1 | Output enable for the data pad driver |
| peakHitLeft | input | 1 | Left overload detector pulse |
| peakHitRight | input | 1 | Right overload detector pulse |
| tapSignals | input | 8 | Internal signals that can be shown on the mute pad |
| muteOut | output | 1 | Value for the mute pad in test mode |
| muteOe | output | 1 | Output enable for the mute pad |
| gainLeft | output | 8 | Left gain code |
| gainRight | output | 8 | Right gain code |
| peakRef | output | 8 | Peak comparator reference code |
| gainLeftStb | output | 1 | One-cycle pulse on a left gain load |
| gainRightStb | output | 1 | One-cycle pulse on a right gain load |

## Verification
The bench runs the following corner cases:

- **Aborted frame.** A frame is cut short after ten bits. A port that committed partial frames would load a shifted, garbled byte and fire a strobe.
- **Overload pulse during a status read.** A pulse arrives while the status byte is being shifted out. A port that cleared the whole status register would silently lose that event, and the following read would show zero.
- **Alias write.** A write to the alias address must load both channels. A port that decoded it as a single channel would leave one gain stale, or would fire the two strobes in different cycles.
- **Reads.** Reads of the reference code after reset, of the alias address and of an unmapped address catch a wrong reset default and a read path that leaks stale data.
- **Don't-care bits.** Flipping the don't-care bits in the address byte exposes an off-by-one field decode.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 2 * BYTE_W;
  localparam int FLAG_W  = 2;

  localparam logic [3:0] ADDR_BOTH   = 4'b1001;
  localparam logic [3:0] ADDR_STATUS = 4'b1011;
  localparam logic [3:0] ADDR_REF    = 4'b1100;
  localparam logic [3:0] ADDR_LEFT   = 4'b1101;
  localparam logic [3:0] ADDR_RIGHT  = 4'b1110;
  localparam logic [3:0] ADDR_TEST   = 4'b1111;

  typedef struct packed {
    logic              wrLeft;
    logic              wrRight;
    logic              wrBoth;
    logic              wrRef;
    logic              wrTest;
    logic              clrStat;
    logic [3:0]        addr;
    logic [BYTE_W-1:0] data;
  } port_cmd_t;
endpackage

// File: rtl/srp_frame_ctrl.sv
module srp_frame_ctrl
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              selN,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdValue,
  output port_cmd_t         cmd,
  output logic              sdaOut,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] clkPipe, selPipe, datPipe;
  logic clkPrev, clkSync, datBit, selActive, rise, fall;
  logic [CNT_W-1:0] bitCnt;
  logic [FRAME_W-2:0] shiftIn;
  logic [FRAME_W-1:0] frameWord;
  logic [BYTE_W-1:0] rdLatch;
  logic isRead, commit, addrDone;
  logic [IDX_W-1:0] outIdx;
  logic unusedBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      selPipe <= '1;
      datPipe <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-2:0], serClk};
      selPipe <= {selPipe[SYNC_STAGES-2:0], selN};
      datPipe <= {datPipe[SYNC_STAGES-2:0], sdaIn};
      clkPrev <= clkSync;
    end
  end

  assign clkSync   = clkPipe[SYNC_STAGES-1];
  assign datBit    = datPipe[SYNC_STAGES-1];
  assign selActive = ~selPipe[SYNC_STAGES-1];
  assign rise      = selActive & clkSync & ~clkPrev;
  assign fall      = selActive & ~clkSync & clkPrev;
  assign frameWord = {shiftIn, datBit};
  assign addrDone  = rise && (bitCnt == CNT_W'(BYTE_W - 1));
  assign commit    = rise && (bitCnt == CNT_W'(FRAME_W - 1));
  assign outIdx    = IDX_W'(CNT_W'(FRAME_W - 1) - bitCnt);
  assign unusedBits = &{frameWord[FRAME_W-1], frameWord[BYTE_W+1:BYTE_W]};

  always_comb begin
    cmd = '0;
    cmd.data = frameWord[BYTE_W-1:0];
    cmd.addr = (bitCnt < CNT_W'(BYTE_W)) ? frameWord[6:3] : frameWord[BYTE_W+6:BYTE_W+3];
    if (commit) begin
      if (!frameWord[BYTE_W+2]) begin
        case (cmd.addr)
          ADDR_LEFT:  cmd.wrLeft  = 1'b1;
          ADDR_RIGHT: cmd.wrRight = 1'b1;
          ADDR_BOTH:  cmd.wrBoth  = 1'b1;
          ADDR_REF:   cmd.wrRef   = 1'b1;
          ADDR_TEST:  cmd.wrTest  = 1'b1;
          default:    ;
        endcase
      end else if (cmd.addr == ADDR_STATUS) begin
        cmd.clrStat = 1'b1;
        cmd.data    = rdLatch;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
      rdLatch <= '0;
      isRead  <= 1'b0;
      sdaOut  <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (!selActive) begin
      bitCnt <= '0;
      isRead <= 1'b0;
      sdaOe  <= 1'b0;
    end else begin
      if (rise) begin
        shiftIn <= frameWord[FRAME_W-2:0];
        if (bitCnt != CNT_W'(FRAME_W)) bitCnt <= bitCnt + 1'b1;
      end
      if (addrDone) begin
        rdLatch <= rdValue;
        isRead  <= frameWord[2];
      end
      if (fall) begin
        if (isRead && bitCnt >= CNT_W'(BYTE_W) && bitCnt < CNT_W'(FRAME_W)) begin
          sdaOe  <= 1'b1;
          sdaOut <= rdLatch[outIdx];
        end else begin
          sdaOe <= 1'b0;
        end
      end
    end
  end

  // R6
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |=> !sdaOe);

  // R3
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.wrLeft, cmd.wrRight, cmd.wrBoth, cmd.wrRef, cmd.wrTest, cmd.clrStat}));
endmodule

// File: rtl/srp_reg_file.sv
module srp_reg_file
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  port_cmd_t         cmd,
  input  logic              peakHitLeft,
  input  logic              peakHitRight,
  input  logic [BYTE_W-1:0] tapSignals,
  output logic [BYTE_W-1:0] rdValue,
  output logic [BYTE_W-1:0] gainLeft,
  output logic [BYTE_W-1:0] gainRight,
  output logic [BYTE_W-1:0] peakRef,
  output logic              gainLeftStb,
  output logic              gainRightStb,
  output logic              muteOut,
  output logic              muteOe
);
  logic [BYTE_W-1:0] testReg;
  logic [FLAG_W-1:0] statusReg, clrMask;
  logic loadLeft, loadRight;

  assign loadLeft  = cmd.wrLeft  | cmd.wrBoth;
  assign loadRight = cmd.wrRight | cmd.wrBoth;
  assign clrMask   = cmd.clrStat ? cmd.data[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainLeft     <= '0;
      gainRight    <= '0;
      peakRef      <= '1;
      testReg      <= '0;
      statusReg    <= '0;
      gainLeftStb  <= 1'b0;
      gainRightStb <= 1'b0;
    end else begin
      gainLeftStb  <= loadLeft;
      gainRightStb <= loadRight;
      if (loadLeft)   gainLeft  <= cmd.data;
      if (loadRight)  gainRight <= cmd.data;
      if (cmd.wrRef)  peakRef   <= cmd.data;
      if (cmd.wrTest) testReg   <= cmd.data;
      statusReg <= (statusReg & ~clrMask) | {peakHitLeft, peakHitRight};
    end
  end

  always_comb begin
    case (cmd.addr)
      ADDR_STATUS: rdValue = {{(BYTE_W-FLAG_W){1'b0}}, statusReg};
      ADDR_REF:    rdValue = peakRef;
      ADDR_LEFT:   rdValue = gainLeft;
      ADDR_RIGHT:  rdValue = gainRight;
      ADDR_TEST:   rdValue = testReg;
      default:     rdValue = '0;
    endcase
  end

  assign muteOe  = testReg[1];
  assign muteOut = testReg[1] & tapSignals[testReg[4:2]];

  // R7
  stat_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    peakHitLeft |=> statusReg[1]);

  // R3
  ref_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrRef |=> (peakRef == $past(cmd.data)));

  // R8
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadLeft |=> ($stable(gainLeft) && !gainLeftStb));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              selN,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  input  logic              peakHitLeft,
  input  logic              peakHitRight,
  input  logic [BYTE_W-1:0] tapSignals,
  output logic              muteOut,
  output logic              muteOe,
  output logic [BYTE_W-1:0] gainLeft,
  output logic [BYTE_W-1:0] gainRight,
  output logic [BYTE_W-1:0] peakRef,
  output logic              gainLeftStb,
  output logic              gainRightStb
);
  port_cmd_t cmd;
  logic [BYTE_W-1:0] rdValue;

  srp_frame_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .selN(selN), .sdaIn(sdaIn),
    .rdValue(rdValue), .cmd(cmd), .sdaOut(sdaOut), .sdaOe(sdaOe)
  );

  srp_reg_file i_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .peakHitLeft(peakHitLeft), .peakHitRight(peakHitRight), .tapSignals(tapSignals),
    .rdValue(rdValue), .gainLeft(gainLeft), .gainRight(gainRight), .peakRef(peakRef),
    .gainLeftStb(gainLeftStb), .gainRightStb(gainRightStb),
    .muteOut(muteOut), .muteOe(muteOe)
  );
endmodule

// File: tb/test_serial_reg_port.sv
module test_serial_reg_port;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, serClk = 1'b0, selN = 1'b1, sdaIn = 1'b0;
  logic hitL = 1'b0, hitR = 1'b0;
  logic [7:0] taps = 8'h00;
  logic sdaOut, sdaOe, muteOut, muteOe, stbL, stbR;
  logic [7:0] gainL, gainR, pref;

  int nChecks = 0, nFail = 0, stbLCnt = 0, stbRCnt = 0, bothCnt = 0;
  int expStbL = 0, expStbR = 0, expBoth = 0, idleCnt = 0;
  logic [7:0] expL = 8'h00, expR = 8'h00, expRef = 8'hFF, expTest = 8'h00;
  logic [1:0] expStat = 2'b00;
  bit settled = 0, done = 0;

  always #4 clk = ~clk;

  serial_reg_port i_serial_reg_port (
    .clk(clk), .rstN(rstN), .serClk(serClk), .selN(selN), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .peakHitLeft(hitL), .peakHitRight(hitR),
    .tapSignals(taps), .muteOut(muteOut), .muteOe(muteOe),
    .gainLeft(gainL), .gainRight(gainR), .peakRef(pref),
    .gainLeftStb(stbL), .gainRightStb(stbR)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (stbL) stbLCnt++;
    if (stbR) stbRCnt++;
    if (stbL && stbR) bothCnt++;
  end

  // every-clock comparison against the model while no frame is in flight
  always @(negedge clk) begin
    idleCnt = selN ? idleCnt + 1 : 0;
    if (rstN && idleCnt > 4) check("R6 idle sdaOe", sdaOe, 0);
    if (settled) begin
      check("R3 gainLeft", gainL, expL);
      check("R3 gainRight", gainR, expR);
      check("R3 peakRef", pref, expRef);
      check("R9 muteOe", muteOe, expTest[1]);
      check("R9 muteOut", muteOut, expTest[1] & taps[expTest[4:2]]);
    end
  end

  function automatic logic [7:0] modelRead(input logic [3:0] a);
    case (a)
      4'b1011: return {6'b0, expStat};
      4'b1100: return expRef;
      4'b1101: return expL;
      4'b1110: return expR;
      4'b1111: return expTest;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] aByte(input logic [3:0] a, input logic rd, input logic dc);
    return {dc, a, rd, dc, dc};
  endfunction

  task automatic frame(input logic [7:0] ab, input logic [7:0] db, input int nBits,
                       input int pb, input logic [1:0] hitMask, output logic [7:0] got);
    logic [3:0] a;
    logic rd;
    logic [7:0] rdExp;
    logic oeAll;
    a = ab[6:3];
    rd = ab[2];
    rdExp = modelRead(a);
    got = 8'h00;
    oeAll = 1'b1;
    settled = 0;
    selN = 1'b0;
    waitCyc(HALF);
    for (int i = 0; i < nBits; i++) begin
      serClk = 1'b0;
      sdaIn = (i < 8) ? ab[7-i] : db[15-i];
      if (i == pb) begin
        hitL = hitMask[1];
        hitR = hitMask[0];
        expStat = expStat | hitMask;
        waitCyc(1);
        hitL = 1'b0;
        hitR = 1'b0;
        waitCyc(HALF - 1);
      end else begin
        waitCyc(HALF);
      end
      if (i >= 8) begin
        got[15-i] = sdaOut;
        oeAll = oeAll & sdaOe;
      end
      serClk = 1'b1;
      waitCyc(HALF);
    end
    serClk = 1'b0;
    waitCyc(HALF);
    if (nBits == 16) check("R6 oe after last fall", sdaOe, 0);
    selN = 1'b1;
    waitCyc(HALF);
    if (nBits == 16) begin
      if (rd) begin
        check("R5 read data", got, rdExp);
        check("R5 read oe", oeAll, 1);
        if (a == 4'b1011) expStat = expStat & ~rdExp[1:0];
      end else begin
        case (a)
          4'b1101: begin expL = db; expStbL++; end
          4'b1110: begin expR = db; expStbR++; end
          4'b1001: begin expL = db; expR = db; expStbL++; expStbR++; expBoth++; end
          4'b1100: expRef = db;
          4'b1111: expTest = db;
          default: ;
        endcase
      end
    end
    settled = 1;
    waitCyc(2);
    check("R3 left strobe count", stbLCnt, expStbL);
    check("R3 right strobe count", stbRCnt, expStbR);
    check("R4 joint strobes", bothCnt, expBoth);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] g;
    frame(aByte(a, 1'b0, 1'b1), d, 16, -1, 2'b00, g);
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] g);
    frame(aByte(a, 1'b1, 1'b1), 8'hA5, 16, -1, 2'b00, g);
  endtask

  task automatic pulse(input logic [1:0] m);
    hitL = m[1];
    hitR = m[0];
    expStat = expStat | m;
    waitCyc(1);
    hitL = 1'b0;
    hitR = 1'b0;
    waitCyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishUp();
  end

  initial begin
    logic [7:0] g;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(4);
    // R1 reset state
    check("R1 gainLeft", gainL, 0);
    check("R1 gainRight", gainR, 0);
    check("R1 peakRef", pref, 255);
    check("R1 sdaOe", sdaOe, 0);
    check("R1 muteOe", muteOe, 0);
    settled = 1;
    rdReg(4'b1100, g);          // R1 reference reads back 255
    rdReg(4'b1011, g);          // R1 status reads 0
    rdReg(4'b1111, g);          // R1 test reads 0
    // R2 don't-care bits cleared, then set
    frame(aByte(4'b1101, 1'b0, 1'b0), 8'h5A, 16, -1, 2'b00, g);
    wr(4'b1110, 8'hC3);         // R3 right gain
    wr(4'b1100, 8'h40);         // R3 reference
    rdReg(4'b1100, g);          // R5
    wr(4'b1001, 8'h77);         // R4 alias loads both
    rdReg(4'b1101, g);          // R5 left
    rdReg(4'b1110, g);          // R5 right
    rdReg(4'b1001, g);          // R5 alias reads 0
    rdReg(4'b0010, g);          // R5 unmapped reads 0
    // R8 aborted frame after ten bits
    frame(aByte(4'b1101, 1'b0, 1'b1), 8'hEE, 10, -1, 2'b00, g);
    wr(4'b1101, 8'h12);         // R8 next frame decodes normally
    wr(4'b1011, 8'hFF);         // R8 write to status ignored
    rdReg(4'b1011, g);
    // R7 sticky flags
    pulse(2'b10);
    rdReg(4'b1011, g);          // expect 2
    rdReg(4'b1011, g);          // expect 0 after clear
    pulse(2'b11);
    rdReg(4'b1011, g);          // expect 3
    pulse(2'b01);
    // R7 left pulse during the data phase of a status read survives the clear
    frame(aByte(4'b1011, 1'b1, 1'b1), 8'h00, 16, 10, 2'b10, g);
    rdReg(4'b1011, g);          // expect 2
    rdReg(4'b1011, g);          // expect 0
    // R9 test mode routing
    taps = 8'b0010_0000;
    wr(4'b1111, 8'h16);
    check("R9 muteOe set", muteOe, 1);
    check("R9 muteOut tap5", muteOut, 1);
    taps = 8'b1101_1111;
    waitCyc(2);
    check("R9 muteOut tap5 low", muteOut, 0);
    rdReg(4'b1111, g);          // R5 test read
    wr(4'b1111, 8'h00);
    check("R9 muteOe clear", muteOe, 0);
    waitCyc(20);
    finishUp();
  end
endmodule